// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is one output-compare channel of a general-purpose timer. Each clock it compares an externally supplied counter value with its active compare register. From the result it builds an active-high reference waveform in one of eight selectable modes. The reference drives a main pin and a complementary pin, and each pin has its own polarity bit. The counter, dead-time insertion, break handling and the register bus all live outside the block. The block receives the counter value, a one-cycle update pulse and a one-cycle trigger pulse.

The compare register can be written straight into its active copy. Alternatively it can be written into a shadow copy that moves to the active copy only on an update pulse, so a period in progress is never disturbed. In the two pulse-width modes, a trigger pulse can act as an immediate compare match when the fast-trigger bit is set. This gives a short, fixed trigger-to-output latency. A lock input freezes the mode and preload fields while the channel is used as an output.

Top module: `occh_unit`

## Requirements
- R1: After reset the reference is low, the mode is frozen (code 000), preload and fast trigger are off, both polarity bits are 0 and the active compare value is 0, so `oc_main` is 0 and `oc_comp` is 1.
- R2: A polarity bit of 0 means active high. `oc_main` equals the reference when `cfg_pol_main` is 0 and its inverse when it is 1. `oc_comp` equals the inverse of the reference when `cfg_pol_comp` is 0 and the reference itself when it is 1.
- R3: In frozen mode (code 000) the reference holds its value whatever the counter and compare values are.
- R4: In set mode (code 001) a match (counter equal to the active compare value) drives the reference high at the next clock edge. In clear mode (010) a match drives it low. In toggle mode (011) it inverts on every clock cycle in which a match holds.
- R5: Mode 100 drives the reference low and mode 101 drives it high at the next clock edge, independent of the counter.
- R6: In pwm-low-after mode (110) the reference is high while the counter is below the compare value and low otherwise. Mode 111 gives the inverse. In these two modes the reference is re-evaluated only when the below-compare result differs from its value one cycle earlier, or in the first cycle after the mode leaves frozen.
- R7: With preload off, a compare write reaches the active compare value at the next edge and is used by the comparison from the following cycle.
- R8: With preload on, a compare write goes only to the shadow register. The shadow is copied to the active value at the edge that samples an update pulse. If a write and an update coincide, the copy takes the old shadow value.
- R9: With the fast-trigger bit set and a pwm mode selected, a trigger pulse forces the reference to its post-compare level (low in 110, high in 111) whatever the comparison says. The change appears at the third rising edge counted from the edge that samples the trigger.
- R10: A trigger pulse has no effect on the reference when the fast-trigger bit is clear, or when the mode is not 110 or 111.
- R11: While `lock_max` and `is_output` are both high, configuration writes leave the mode and preload-enable fields unchanged. The fast-trigger and polarity fields are still written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | CNT_W | Current counter value from the external timer |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Mode code to write |
| cfg_pre_en | input | 1 | Preload enable to write |
| cfg_fast_en | input | 1 | Fast-trigger enable to write |
| cfg_pol_main | input | 1 | Main pin polarity to write (1 = active low) |
| cfg_pol_comp | input | 1 | Complementary pin polarity to write (1 = active low) |
| lock_max | input | 1 | Highest lock level active |
| is_output | input | 1 | Channel configured as an output |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | CNT_W | Compare value to write |
| upd_evt | input | 1 | Update event pulse |
| trig_evt | input | 1 | Trigger event pulse |
| oc_ref | output | 1 | Active-high reference waveform |
| oc_main | output | 1 | Main output pin |
| oc_comp | output | 1 | Complementary output pin |

## Verification
The assertions watch the cycle-local rules on every clock. They check that frozen mode holds the reference, that the force modes and the set and clear matches take effect one edge later, that the two pins stay complementary under their polarities, that a locked write leaves the mode unchanged, that the active compare value only moves on an update while preload is on, and that a fast trigger in mode 111 sets the reference. Some behaviours only the bench scenarios can show: the exact three-edge trigger latency, the absence of any trigger effect with fast trigger clear or outside the pwm modes, and the pwm rule that the reference moves only on a change of the comparison or on leaving frozen. The same holds for preload timing, where a write is visible only after a later update. The bench covers these with a cycle model, using random mode sweeps and mid-period compare writes.

// File: rtl/occh_pkg.sv
package occh_pkg;

  typedef enum logic [2:0] {
    OCM_FROZEN = 3'b000,
    OCM_SET    = 3'b001,
    OCM_CLR    = 3'b010,
    OCM_TGL    = 3'b011,
    OCM_LOW    = 3'b100,
    OCM_HIGH   = 3'b101,
    OCM_PWM1   = 3'b110,
    OCM_PWM2   = 3'b111
  } oc_mode_e;

  typedef struct packed {
    oc_mode_e mode;
    logic     pre_en;
    logic     fast_en;
    logic     pol_main;
    logic     pol_comp;
  } oc_cfg_t;

  // true for the two pulse-width modes
  function automatic logic mode_is_pwm(oc_mode_e m);
    return (m == OCM_PWM1) || (m == OCM_PWM2);
  endfunction

  // reference level of a pwm mode given the below-compare result
  function automatic logic pwm_level(oc_mode_e m, logic below);
    return (m == OCM_PWM1) ? below : ~below;
  endfunction

  // level a pwm mode takes once the compare point is reached
  function automatic logic post_cmp_level(oc_mode_e m);
    return (m == OCM_PWM2);
  endfunction

  // apply a polarity bit (1 = active low) to an active-high level
  function automatic logic drive_pin(logic active, logic pol);
    return active ^ pol;
  endfunction

endpackage

// File: rtl/occh_cfg.sv
module occh_cfg
  import occh_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  logic     lock_hold,
  input  oc_cfg_t  wr_cfg,
  output oc_cfg_t  cfg_q,
  output oc_mode_e prev_mode_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q       <= '{mode: OCM_FROZEN, default: 1'b0};
      prev_mode_q <= OCM_FROZEN;
    end else begin
      prev_mode_q <= cfg_q.mode;
      if (wr_en) begin
        cfg_q.fast_en  <= wr_cfg.fast_en;
        cfg_q.pol_main <= wr_cfg.pol_main;
        cfg_q.pol_comp <= wr_cfg.pol_comp;
        if (!lock_hold) begin
          cfg_q.mode   <= wr_cfg.mode;
          cfg_q.pre_en <= wr_cfg.pre_en;
        end
      end
    end
  end

endmodule

// File: rtl/occh_ccr.sv
module occh_ccr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_en,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             upd,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp_act_q,
  output logic             match,
  output logic             below
);

  logic [CNT_W-1:0] cmp_shd_q;
  logic [CNT_W-1:0] act_d;
  logic [CNT_W-1:0] shd_d;

  always_comb begin
    act_d = cmp_act_q;
    shd_d = cmp_shd_q;
    if (wr_en) shd_d = wr_data;
    if (pre_en) begin
      if (upd) act_d = cmp_shd_q;
    end else if (wr_en) begin
      act_d = wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_act_q <= '0;
      cmp_shd_q <= '0;
    end else begin
      cmp_act_q <= act_d;
      cmp_shd_q <= shd_d;
    end
  end

  assign match = (cnt == cmp_act_q);
  assign below = (cnt <  cmp_act_q);

endmodule

// File: rtl/occh_fast.sv
module occh_fast #(
  parameter int FAST_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic fire
);

  localparam int STAGES = FAST_LAT - 1;

  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= trig;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], trig};
      end
    end
  endgenerate

  assign fire = pipe_q[STAGES-1];

endmodule

// File: rtl/occh_refgen.sv
module occh_refgen
  import occh_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  oc_mode_e mode,
  input  oc_mode_e prev_mode,
  input  logic     fast_en,
  input  logic     match,
  input  logic     below,
  input  logic     fire,
  output logic     ref_q,
  output logic     fast_hit
);

  logic below_prev_q;
  logic ref_d;
  logic pwm_eval;

  assign fast_hit = fire & fast_en & mode_is_pwm(mode);
  assign pwm_eval = (prev_mode == OCM_FROZEN) || (below != below_prev_q);

  always_comb begin
    ref_d = ref_q;
    unique case (mode)
      OCM_FROZEN: ref_d = ref_q;
      OCM_SET:    if (match) ref_d = 1'b1;
      OCM_CLR:    if (match) ref_d = 1'b0;
      OCM_TGL:    if (match) ref_d = ~ref_q;
      OCM_LOW:    ref_d = 1'b0;
      OCM_HIGH:   ref_d = 1'b1;
      OCM_PWM1, OCM_PWM2: begin
        if (fast_hit)      ref_d = post_cmp_level(mode);
        else if (pwm_eval) ref_d = pwm_level(mode, below);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q        <= 1'b0;
      below_prev_q <= 1'b0;
    end else begin
      ref_q        <= ref_d;
      below_prev_q <= below;
    end
  end

endmodule

// File: rtl/occh_unit.sv
module occh_unit
  import occh_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int FAST_LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_mode,
  input  logic             cfg_pre_en,
  input  logic             cfg_fast_en,
  input  logic             cfg_pol_main,
  input  logic             cfg_pol_comp,
  input  logic             lock_max,
  input  logic             is_output,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             upd_evt,
  input  logic             trig_evt,
  output logic             oc_ref,
  output logic             oc_main,
  output logic             oc_comp
);

  oc_cfg_t          wr_cfg;
  oc_cfg_t          cfg_q;
  oc_mode_e         prev_mode_q;
  logic             lock_hold_w;
  logic             match_w;
  logic             below_w;
  logic             fire_w;
  logic             fast_hit_w;
  logic [CNT_W-1:0] cmp_act_w;
  logic [2:0]       mode_w;
  logic             pre_en_w;
  logic             fast_en_w;
  logic             pol_main_w;
  logic             pol_comp_w;

  assign lock_hold_w     = lock_max & is_output;
  assign wr_cfg.mode     = oc_mode_e'(cfg_mode);
  assign wr_cfg.pre_en   = cfg_pre_en;
  assign wr_cfg.fast_en  = cfg_fast_en;
  assign wr_cfg.pol_main = cfg_pol_main;
  assign wr_cfg.pol_comp = cfg_pol_comp;

  occh_cfg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (cfg_we),
    .lock_hold   (lock_hold_w),
    .wr_cfg      (wr_cfg),
    .cfg_q       (cfg_q),
    .prev_mode_q (prev_mode_q)
  );

  assign mode_w     = cfg_q.mode;
  assign pre_en_w   = cfg_q.pre_en;
  assign fast_en_w  = cfg_q.fast_en;
  assign pol_main_w = cfg_q.pol_main;
  assign pol_comp_w = cfg_q.pol_comp;

  occh_ccr #(.CNT_W(CNT_W)) u_ccr (
    .clk       (clk),
    .rst_n     (rst_n),
    .pre_en    (pre_en_w),
    .wr_en     (cmp_we),
    .wr_data   (cmp_wdata),
    .upd       (upd_evt),
    .cnt       (cnt_val),
    .cmp_act_q (cmp_act_w),
    .match     (match_w),
    .below     (below_w)
  );

  occh_fast #(.FAST_LAT(FAST_LAT)) u_fast (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (trig_evt),
    .fire  (fire_w)
  );

  occh_refgen u_ref (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (cfg_q.mode),
    .prev_mode (prev_mode_q),
    .fast_en   (fast_en_w),
    .match     (match_w),
    .below     (below_w),
    .fire      (fire_w),
    .ref_q     (oc_ref),
    .fast_hit  (fast_hit_w)
  );

  assign oc_main = drive_pin(oc_ref, pol_main_w);
  assign oc_comp = drive_pin(~oc_ref, pol_comp_w);

endmodule

// File: rtl/occh_unit_chk.sv
module occh_unit_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode_w,
  input logic             pre_en_w,
  input logic             fast_en_w,
  input logic             pol_main_w,
  input logic             pol_comp_w,
  input logic             match_w,
  input logic             fire_w,
  input logic             lock_hold_w,
  input logic             cfg_we,
  input logic             upd_evt,
  input logic [CNT_W-1:0] cmp_act_w,
  input logic             oc_ref,
  input logic             oc_main,
  input logic             oc_comp
);

  AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == 3'b000) |=> $stable(oc_ref)); // R3
  AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == 3'b001 && match_w) |=> oc_ref); // R4
  AST_CLR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == 3'b010 && match_w) |=> !oc_ref); // R4
  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == 3'b100) |=> !oc_ref); // R5
  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == 3'b101) |=> oc_ref); // R5
  AST_PIN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_main ^ oc_comp) == !(pol_main_w ^ pol_comp_w)); // R2
  AST_LOCKED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_hold_w && cfg_we) |=> $stable(mode_w)); // R11
  AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_en_w && !upd_evt) |=> $stable(cmp_act_w)); // R8
  AST_FAST_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_w && fast_en_w && mode_w == 3'b111) |=> oc_ref); // R9

endmodule

bind occh_unit occh_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_w      (mode_w),
  .pre_en_w    (pre_en_w),
  .fast_en_w   (fast_en_w),
  .pol_main_w  (pol_main_w),
  .pol_comp_w  (pol_comp_w),
  .match_w     (match_w),
  .fire_w      (fire_w),
  .lock_hold_w (lock_hold_w),
  .cfg_we      (cfg_we),
  .upd_evt     (upd_evt),
  .cmp_act_w   (cmp_act_w),
  .oc_ref      (oc_ref),
  .oc_main     (oc_main),
  .oc_comp     (oc_comp)
);

// File: tb/occh_unit_tb.sv
module occh_unit_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cnt_val = '0;
  logic         cfg_we = 1'b0;
  logic [2:0]   cfg_mode = 3'd0;
  logic         cfg_pre_en = 1'b0, cfg_fast_en = 1'b0;
  logic         cfg_pol_main = 1'b0, cfg_pol_comp = 1'b0;
  logic         lock_max = 1'b0, is_output = 1'b0;
  logic         cmp_we = 1'b0;
  logic [W-1:0] cmp_wdata = '0;
  logic         upd_evt = 1'b0, trig_evt = 1'b0;
  logic         oc_ref, oc_main, oc_comp;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  occh_unit #(.CNT_W(W), .FAST_LAT(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cfg_we(cfg_we),
    .cfg_mode(cfg_mode), .cfg_pre_en(cfg_pre_en), .cfg_fast_en(cfg_fast_en),
    .cfg_pol_main(cfg_pol_main), .cfg_pol_comp(cfg_pol_comp),
    .lock_max(lock_max), .is_output(is_output), .cmp_we(cmp_we),
    .cmp_wdata(cmp_wdata), .upd_evt(upd_evt), .trig_evt(trig_evt),
    .oc_ref(oc_ref), .oc_main(oc_main), .oc_comp(oc_comp)
  );

  // ---------------- cycle model built from the requirements ----------------
  logic [2:0]   m_mode, m_prev;
  logic         m_pre, m_fast, m_pm, m_pc;
  logic [W-1:0] m_act, m_shd;
  logic         m_ref, m_lastbelow, m_t0, m_t1;

  function automatic string tag_of(logic [2:0] md);
    case (md)
      3'd0:                 return "R3";
      3'd1, 3'd2, 3'd3:     return "R4";
      3'd4, 3'd5:           return "R5";
      default:              return "R6";
    endcase
  endfunction

  // next reference level for one mode, worked out case by case
  function automatic logic next_ref(logic [2:0] md, logic [2:0] pv, logic cur,
                                    logic eq, logic lt, logic lt_old, logic hit);
    logic r;
    r = cur;
    if (md == 3'd1 && eq) r = 1'b1;
    if (md == 3'd2 && eq) r = 1'b0;
    if (md == 3'd3 && eq) r = !cur;
    if (md == 3'd4) r = 1'b0;
    if (md == 3'd5) r = 1'b1;
    if (md[2:1] == 2'b11) begin
      if (hit)                            r = md[0];
      else if (pv == 3'd0 || lt != lt_old) r = md[0] ? !lt : lt;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 3'd0; m_prev = 3'd0; m_pre = 0; m_fast = 0; m_pm = 0; m_pc = 0;
      m_act = '0; m_shd = '0; m_ref = 0; m_lastbelow = 0; m_t0 = 0; m_t1 = 0;
    end else begin
      logic lt, eq, hit;
      lt  = cnt_val < m_act;
      eq  = cnt_val == m_act;
      hit = m_t1 && m_fast && (m_mode[2:1] == 2'b11);
      m_ref       = next_ref(m_mode, m_prev, m_ref, eq, lt, m_lastbelow, hit);
      m_lastbelow = lt;
      m_prev      = m_mode;
      m_t1 = m_t0; m_t0 = trig_evt;
      if (m_pre && upd_evt) m_act = m_shd;
      if (cmp_we) begin
        m_shd = cmp_wdata;
        if (!m_pre) m_act = cmp_wdata;
      end
      if (cfg_we) begin
        m_fast = cfg_fast_en; m_pm = cfg_pol_main; m_pc = cfg_pol_comp;
        if (!(lock_max && is_output)) begin
          m_mode = cfg_mode; m_pre = cfg_pre_en;
        end
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic bad;
      bad = 0;
      vectors++;
      if (oc_ref !== m_ref) begin
        bad = 1;
        $display("FAIL %s mode=%0d oc_ref actual=%b expected=%b", tag_of(m_mode), m_mode, oc_ref, m_ref);
      end
      if (oc_main !== (m_ref ^ m_pm) || oc_comp !== (!m_ref ^ m_pc)) begin
        bad = 1;
        $display("FAIL R2 pins actual=%b%b expected=%b%b", oc_main, oc_comp, m_ref ^ m_pm, !m_ref ^ m_pc);
      end
      if (bad) fails++;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wcfg(input logic [2:0] md, input logic pre, input logic fst,
                      input logic pm, input logic pc);
    cfg_mode = md; cfg_pre_en = pre; cfg_fast_en = fst;
    cfg_pol_main = pm; cfg_pol_comp = pc; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wcmp(input int v);
    cmp_wdata = W'(v); cmp_we = 1;
    @(negedge clk);
    cmp_we = 0;
  endtask

  task automatic pulse_trig_and_wait(input int n);
    trig_evt = 1;
    @(negedge clk);
    trig_evt = 0;
    tick(n);
  endtask

  task automatic finish_run;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=%0d cycles expected=completion", cyc);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd20240611));
    tick(4);
    // R1: reset values at the pins
    chk("R1", "oc_ref in reset", int'(oc_ref), 0);
    chk("R1", "oc_main in reset", int'(oc_main), 0);
    chk("R1", "oc_comp in reset", int'(oc_comp), 1);
    rst_n = 1;
    // R3/R1: counter equals reset compare 0 while frozen: reference stays low
    tick(4);
    chk("R3", "frozen ignores match", int'(oc_ref), 0);

    // R6/R7: hold counter at 7, pwm1, preload off
    cnt_val = 16'd7;
    wcmp(10);
    wcfg(3'd6, 0, 0, 0, 0);
    tick(2);
    chk("R6", "pwm1 below compare", int'(oc_ref), 1);
    wcmp(5);
    tick(1);
    chk("R7", "direct write takes effect", int'(oc_ref), 0);

    // R8: preload on, write lands in shadow only
    wcfg(3'd6, 1, 0, 0, 0);
    wcmp(12);
    tick(3);
    chk("R8", "shadow write not yet active", int'(oc_ref), 0);
    upd_evt = 1;
    @(negedge clk);
    upd_evt = 0;
    tick(1);
    chk("R8", "update copies shadow", int'(oc_ref), 1);

    // R11: lock blocks mode and preload, not polarity
    lock_max = 1; is_output = 1;
    wcfg(3'd4, 0, 0, 1, 0);
    tick(2);
    chk("R11", "locked mode unchanged", int'(oc_ref), 1);
    chk("R11", "polarity still written", int'(oc_main), 0);
    wcmp(3);
    tick(3);
    chk("R11", "locked preload still on", int'(oc_ref), 1);
    is_output = 0;
    wcfg(3'd4, 0, 0, 0, 0);
    tick(1);
    chk("R11", "unlocked write applies", int'(oc_ref), 0);
    lock_max = 0;

    // R9: fast trigger latency in pwm2
    wcmp(200);
    wcfg(3'd0, 0, 1, 0, 0);
    wcfg(3'd7, 0, 1, 0, 0);
    tick(2);
    chk("R6", "pwm2 below compare", int'(oc_ref), 0);
    begin
      int n;
      bit got;
      n = 0; got = 0;
      trig_evt = 1;
      for (int k = 0; k < 8 && !got; k++) begin
        @(posedge clk);
        n++;
        @(negedge clk);
        trig_evt = 0;
        if (oc_ref) got = 1;
      end
      chk("R9", "fast trigger edges to output", got ? n : 99, 3);
    end

    // R10: fast clear, then non-pwm mode with fast set
    wcfg(3'd0, 0, 0, 0, 0);
    wcfg(3'd7, 0, 0, 0, 0);
    tick(2);
    pulse_trig_and_wait(8);
    chk("R10", "trigger with fast clear", int'(oc_ref), 0);
    wcfg(3'd3, 0, 1, 0, 0);
    pulse_trig_and_wait(8);
    chk("R10", "trigger in toggle mode", int'(oc_ref), 0);

    // random sweep across every mode, the cycle model checks each cycle
    for (int s = 0; s < 64; s++) begin
      int per;
      int c;
      per = 6 + int'($urandom % 20);
      lock_max  = (($urandom % 4) == 0);
      is_output = $urandom % 2;
      cmp_wdata = W'($urandom % (per + 3));
      cmp_we = 1;
      wcfg(3'(s % 8), $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
      cmp_we = 0;
      c = int'(cnt_val) % per;
      for (int k = 0; k < 70; k++) begin
        c = (c + 1 >= per) ? 0 : c + 1;
        cnt_val   = W'(c);
        upd_evt   = (c == 0);
        cmp_we    = (($urandom % 10) == 0);
        cmp_wdata = W'($urandom % (per + 3));
        trig_evt  = (($urandom % 14) == 0);
        cfg_we    = (($urandom % 25) == 0);
        cfg_mode  = 3'($urandom % 8);
        cfg_fast_en = $urandom % 2;
        @(negedge clk);
      end
      cfg_we = 0; cmp_we = 0; upd_evt = 0; trig_evt = 0;
    end

    tick(2);
    finish_run();
  end

endmodule